// File: doc/BRIEF.md
# Bus Timing Divisor Search Engine

This unit picks the two clock-division factors for a two-wire serial bus controller. It takes a source clock frequency and a requested bus rate, both in hertz. It searches for the smallest product of a sample count (1 to 8) and a step count that divides the source clock down to a rate at or below the request. The result comes out minus one, so it can go straight into timing fields.

A search starts with a single-cycle `start` pulse while the engine is idle. The engine registers its inputs at that point. It then runs a sequence of divisions on one shared multi-cycle restoring divider:

- one division for the ideal divisor,
- up to eight divisions for the candidate pairs,
- one final division that checks whether the chosen pair still runs faster than the request.

When the search ends, `done` pulses for one cycle. At that point the two factors and the error flag are valid, and they hold until the next search finishes.

Top module: `divsrch_engine`

## Requirements
- R1: While reset is held and right after it is released, `busy`, `done`, `rateErr`, `sampleSel` and `stepSel` are all zero.
- R2: A requested rate above 3,400,000 is handled exactly as a request of 3,400,000.
- R3: The step limit is 8 when the clamped rate is strictly above 400,000. It is 64 when the clamped rate is 400,000 or below.
- R4: The ideal divisor is ceil(floor(src/2) / rate). A divisor of zero is raised to 1.
- R5: The search tries sample counts 1 to 8 in rising order, using step = ceil(ideal/sample).
  - A candidate whose step exceeds the limit is skipped.
  - A candidate replaces the best pair only when its product is strictly smaller.
  - The best pair starts as (8, limit).
  - The search stops after the first accepted candidate whose product equals the ideal divisor.
- R6: `rateErr` is 1 when floor(src / (2·sample·step)) of the chosen pair exceeds the clamped rate. The pair is still reported in that case.
- R7: `sampleSel` carries sample−1 (3 bits) and `stepSel` carries step−1 (6 bits). Both outputs and `rateErr` change only in the cycle `done` is high, and hold until the next search completes.
- R8: `done` is high for exactly one cycle per accepted start. `busy` is high from the edge that accepts `start` until the edge that raises `done`.
- R9: A `start` that arrives while `busy` is high is ignored. The running search keeps its registered inputs, and no extra `done` follows.
- R10: A requested rate of zero gives `rateErr` = 1 with `sampleSel` = 7 and `stepSel` = 63, without any division.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Single-cycle request to begin a search |
| srcHz | input | 32 | Source clock frequency in Hz |
| targetHz | input | 32 | Requested bus rate in Hz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| sampleSel | output | 3 | Chosen sample count minus one |
| stepSel | output | 6 | Chosen step count minus one |
| rateErr | output | 1 | Chosen pair still runs faster than the request |

## Verification
The latency of a search depends on its data: each division takes 33 cycles, and an early stop skips the remaining candidates. For that reason the bench never counts a fixed delay to the result. It checks `busy` one cycle after driving `start`. It then polls `done` on falling edges and compares the outputs in the very cycle `done` is seen. One cycle later it confirms that `done` has dropped and `busy` is low, and twenty cycles later that the outputs are unchanged. The ignored-start scenario watches a further 800 cycles after the first `done`, which is longer than any search takes, to prove that no second `done` appears.

// File: rtl/divsrch_pkg.sv
package divsrch_pkg;

  typedef enum logic [1:0] {
    OPND_IDEAL = 2'd0,
    OPND_STEP  = 2'd1,
    OPND_CHECK = 2'd2
  } opndSel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_IDEAL_GO,
    ST_IDEAL_WAIT,
    ST_STEP_GO,
    ST_STEP_WAIT,
    ST_CHECK_GO,
    ST_CHECK_WAIT,
    ST_FINISH
  } ctrlState_e;

  typedef struct packed {
    logic     loadIn;
    logic     divGo;
    opndSel_e opnd;
    logic     takeIdeal;
    logic     evalCand;
    logic     incSample;
    logic     takeCheck;
    logic     forceErr;
    logic     finish;
  } strobes_t;

  typedef struct packed {
    logic divDone;
    logic tgtZero;
    logic earlyHit;
    logic lastSample;
  } status_t;

endpackage

// File: rtl/divsrch_divider.sv
module divsrch_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem,
  output logic         done
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  partR;
  logic [W-1:0]  quoR;
  logic [W-1:0]  divR;
  logic [CW-1:0] cntR;
  logic          runR;
  logic          doneR;
  logic [W:0]    shifted;
  logic [W:0]    trial;

  assign shifted = {partR, quoR[W-1]};
  assign trial   = shifted - {1'b0, divR};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      partR <= '0;
      quoR  <= '0;
      divR  <= '0;
      cntR  <= '0;
      runR  <= 1'b0;
      doneR <= 1'b0;
    end else begin
      doneR <= 1'b0;
      if (go) begin
        quoR  <= dividend;
        divR  <= divisor;
        partR <= '0;
        cntR  <= CW'(W);
        runR  <= 1'b1;
      end else if (runR) begin
        if (!trial[W]) begin
          partR <= trial[W-1:0];
          quoR  <= {quoR[W-2:0], 1'b1};
        end else begin
          partR <= shifted[W-1:0];
          quoR  <= {quoR[W-2:0], 1'b0};
        end
        cntR <= cntR - 1'b1;
        if (cntR == CW'(1)) begin
          runR  <= 1'b0;
          doneR <= 1'b1;
        end
      end
    end
  end

  assign quo  = quoR;
  assign rem  = partR;
  assign done = doneR;

  // R4: a finished division leaves a remainder below its divisor
  assert_rem_below_div_R4: assert property (@(posedge clk) disable iff (!rstN)
    doneR |-> (partR < divR));

endmodule

// File: rtl/divsrch_ctrl.sv
module divsrch_ctrl
  import divsrch_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  status_t  stat,
  output strobes_t strb,
  output logic     busy,
  output logic     done
);
  ctrlState_e stateR, stateNx;
  logic       doneR;

  always_comb begin
    strb    = '0;
    strb.opnd = OPND_IDEAL;
    stateNx = stateR;
    unique case (stateR)
      ST_IDLE: begin
        if (start) begin
          strb.loadIn = 1'b1;
          stateNx     = ST_IDEAL_GO;
        end
      end
      ST_IDEAL_GO: begin
        if (stat.tgtZero) begin
          strb.forceErr = 1'b1;
          stateNx       = ST_FINISH;
        end else begin
          strb.divGo = 1'b1;
          strb.opnd  = OPND_IDEAL;
          stateNx    = ST_IDEAL_WAIT;
        end
      end
      ST_IDEAL_WAIT: begin
        if (stat.divDone) begin
          strb.takeIdeal = 1'b1;
          stateNx        = ST_STEP_GO;
        end
      end
      ST_STEP_GO: begin
        strb.divGo = 1'b1;
        strb.opnd  = OPND_STEP;
        stateNx    = ST_STEP_WAIT;
      end
      ST_STEP_WAIT: begin
        if (stat.divDone) begin
          strb.evalCand = 1'b1;
          if (stat.earlyHit || stat.lastSample) begin
            stateNx = ST_CHECK_GO;
          end else begin
            strb.incSample = 1'b1;
            stateNx        = ST_STEP_GO;
          end
        end
      end
      ST_CHECK_GO: begin
        strb.divGo = 1'b1;
        strb.opnd  = OPND_CHECK;
        stateNx    = ST_CHECK_WAIT;
      end
      ST_CHECK_WAIT: begin
        if (stat.divDone) begin
          strb.takeCheck = 1'b1;
          stateNx        = ST_FINISH;
        end
      end
      ST_FINISH: begin
        strb.finish = 1'b1;
        stateNx     = ST_IDLE;
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateR <= ST_IDLE;
      doneR  <= 1'b0;
    end else begin
      stateR <= stateNx;
      doneR  <= strb.finish;
    end
  end

  assign busy = (stateR != ST_IDLE);
  assign done = doneR;

  // R8: completion is a single-cycle pulse
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneR |=> !doneR);

  // R8: done is raised only when the engine returns to idle
  assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneR |-> (stateR == ST_IDLE));

endmodule

// File: rtl/divsrch_datapath.sv
module divsrch_datapath
  import divsrch_pkg::*;
#(
  parameter int RATE_W       = 32,
  parameter int SAMPLE_MAX   = 8,
  parameter int STEP_MAX_STD = 64,
  parameter int STEP_MAX_HS  = 8,
  parameter int RATE_CAP     = 3400000,
  parameter int FS_LIMIT     = 400000
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  strobes_t                              strb,
  input  logic                                  busy,
  input  logic [RATE_W-1:0]                     srcIn,
  input  logic [RATE_W-1:0]                     tgtIn,
  output status_t                               stat,
  output logic [$clog2(SAMPLE_MAX)-1:0]         sampleOut,
  output logic [$clog2(STEP_MAX_STD)-1:0]       stepOut,
  output logic                                  errOut
);
  localparam int SAMPLE_W = $clog2(SAMPLE_MAX);
  localparam int STEP_W   = $clog2(STEP_MAX_STD);
  localparam int CNT_W    = $clog2(SAMPLE_MAX + 1);
  localparam int STEPC_W  = $clog2(STEP_MAX_STD + 1);
  localparam int PROD_W   = RATE_W + CNT_W + 1;
  localparam logic [RATE_W-1:0] CAP_V = RATE_W'(RATE_CAP);
  localparam logic [RATE_W-1:0] FS_V  = RATE_W'(FS_LIMIT);

  logic [RATE_W-1:0]  srcR, tgtR, idealR;
  logic [STEPC_W-1:0] limitR, bestStep;
  logic [CNT_W-1:0]   sampleCnt, bestSample;
  logic [PROD_W-1:0]  bestMul;
  logic               errR;

  logic [RATE_W-1:0]  tgtClamp;
  logic [STEPC_W-1:0] limitNew;
  logic [RATE_W-1:0]  dvdSel, dvsSel;
  logic [RATE_W-1:0]  quo, rem, ceilQ;
  logic               divDone;
  logic [PROD_W-1:0]  candMul, checkDiv;
  logic               accept;

  assign tgtClamp = (tgtIn > CAP_V) ? CAP_V : tgtIn;
  assign limitNew = (tgtClamp > FS_V) ? STEPC_W'(STEP_MAX_HS) : STEPC_W'(STEP_MAX_STD);

  assign checkDiv = PROD_W'(2) * PROD_W'(bestSample) * PROD_W'(bestStep);

  always_comb begin
    unique case (strb.opnd)
      OPND_STEP: begin
        dvdSel = idealR;
        dvsSel = RATE_W'(sampleCnt);
      end
      OPND_CHECK: begin
        dvdSel = srcR;
        dvsSel = checkDiv[RATE_W-1:0];
      end
      default: begin
        dvdSel = srcR >> 1;
        dvsSel = tgtR;
      end
    endcase
  end

  divsrch_divider #(.W(RATE_W)) div_i (
    .clk      (clk),
    .rstN     (rstN),
    .go       (strb.divGo),
    .dividend (dvdSel),
    .divisor  (dvsSel),
    .quo      (quo),
    .rem      (rem),
    .done     (divDone)
  );

  assign ceilQ   = quo + RATE_W'(rem != '0);
  assign candMul = PROD_W'(ceilQ) * PROD_W'(sampleCnt);
  assign accept  = (ceilQ <= RATE_W'(limitR)) && (candMul < bestMul);

  assign stat.divDone    = divDone;
  assign stat.tgtZero    = (tgtR == '0);
  assign stat.earlyHit   = accept && (candMul == PROD_W'(idealR));
  assign stat.lastSample = (sampleCnt == CNT_W'(SAMPLE_MAX));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcR       <= '0;
      tgtR       <= '0;
      idealR     <= RATE_W'(1);
      limitR     <= STEPC_W'(STEP_MAX_STD);
      sampleCnt  <= CNT_W'(1);
      bestSample <= CNT_W'(SAMPLE_MAX);
      bestStep   <= STEPC_W'(STEP_MAX_STD);
      bestMul    <= '0;
      errR       <= 1'b0;
      sampleOut  <= '0;
      stepOut    <= '0;
      errOut     <= 1'b0;
    end else begin
      if (strb.loadIn) begin
        srcR       <= srcIn;
        tgtR       <= tgtClamp;
        limitR     <= limitNew;
        sampleCnt  <= CNT_W'(1);
        bestSample <= CNT_W'(SAMPLE_MAX);
        bestStep   <= limitNew;
        bestMul    <= PROD_W'(SAMPLE_MAX) * PROD_W'(limitNew);
        errR       <= 1'b0;
      end
      if (strb.takeIdeal) begin
        idealR <= (ceilQ == '0) ? RATE_W'(1) : ceilQ;
      end
      if (strb.evalCand && accept) begin
        bestSample <= sampleCnt;
        bestStep   <= ceilQ[STEPC_W-1:0];
        bestMul    <= candMul;
      end
      if (strb.incSample) begin
        sampleCnt <= sampleCnt + 1'b1;
      end
      if (strb.takeCheck) begin
        errR <= (quo > tgtR);
      end
      if (strb.forceErr) begin
        errR <= 1'b1;
      end
      if (strb.finish) begin
        sampleOut <= SAMPLE_W'(bestSample - 1'b1);
        stepOut   <= STEP_W'(bestStep - 1'b1);
        errOut    <= errR;
      end
    end
  end

  // R9: registered inputs stay put for the whole search
  assert_inputs_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.loadIn) |=> ($stable(srcR) && $stable(tgtR)));

  // R3: the best step never leaves 1..limit
  assert_step_in_limit_R3: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> ((bestStep <= limitR) && (bestStep != '0)));

  // R5: the best sample count stays within 1..SAMPLE_MAX
  assert_sample_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    (bestSample != '0) && (bestSample <= CNT_W'(SAMPLE_MAX)));

  // R4: the ideal divisor is never zero once taken
  assert_ideal_nonzero_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.takeIdeal |=> (idealR != '0));

endmodule

// File: rtl/divsrch_engine.sv
module divsrch_engine
  import divsrch_pkg::*;
#(
  parameter int RATE_W       = 32,
  parameter int SAMPLE_MAX   = 8,
  parameter int STEP_MAX_STD = 64,
  parameter int STEP_MAX_HS  = 8,
  parameter int RATE_CAP     = 3400000,
  parameter int FS_LIMIT     = 400000
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                start,
  input  logic [RATE_W-1:0]                   srcHz,
  input  logic [RATE_W-1:0]                   targetHz,
  output logic                                busy,
  output logic                                done,
  output logic [$clog2(SAMPLE_MAX)-1:0]       sampleSel,
  output logic [$clog2(STEP_MAX_STD)-1:0]     stepSel,
  output logic                                rateErr
);
  strobes_t strb;
  status_t  stat;

  divsrch_ctrl ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .stat  (stat),
    .strb  (strb),
    .busy  (busy),
    .done  (done)
  );

  divsrch_datapath #(
    .RATE_W       (RATE_W),
    .SAMPLE_MAX   (SAMPLE_MAX),
    .STEP_MAX_STD (STEP_MAX_STD),
    .STEP_MAX_HS  (STEP_MAX_HS),
    .RATE_CAP     (RATE_CAP),
    .FS_LIMIT     (FS_LIMIT)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busy      (busy),
    .srcIn     (srcHz),
    .tgtIn     (targetHz),
    .stat      (stat),
    .sampleOut (sampleSel),
    .stepOut   (stepSel),
    .errOut    (rateErr)
  );

  // R7: results move only in the completion cycle
  assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({sampleSel, stepSel, rateErr}) |-> done);

endmodule

// File: tb/divsrch_engine_tb_top.sv
module divsrch_engine_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] srcHz = '0;
  logic [31:0] targetHz = '0;
  logic        busy, done, rateErr;
  logic [2:0]  sampleSel;
  logic [5:0]  stepSel;

  int errs = 0;
  int checks = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  divsrch_engine dut_i (
    .clk(clk), .rstN(rstN), .start(start), .srcHz(srcHz), .targetHz(targetHz),
    .busy(busy), .done(done), .sampleSel(sampleSel), .stepSel(stepSel), .rateErr(rateErr)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void model(input longint src, input longint tgt,
                                output longint eS, output longint eSt, output longint eErr);
    longint t, lim, ideal, bs, bst, bm, st, m;
    t   = (tgt > 3400000) ? 3400000 : tgt;
    lim = (t > 400000) ? 8 : 64;
    if (t == 0) begin
      eS = 7; eSt = 63; eErr = 1;
      return;
    end
    ideal = ((src / 2) + t - 1) / t;
    if (ideal == 0) ideal = 1;
    bs = 8; bst = lim; bm = 8 * lim;
    for (int s = 1; s <= 8; s++) begin
      st = (ideal + s - 1) / s;
      if (st > lim) continue;
      m = st * s;
      if (m < bm) begin
        bm = m; bs = s; bst = st;
        if (m == ideal) break;
      end
    end
    eS = bs - 1; eSt = bst - 1;
    eErr = ((src / (2 * bs * bst)) > t) ? 1 : 0;
  endfunction

  task automatic waitDone(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done) begin
        seen = 1'b1;
        return;
      end
    end
  endtask

  task automatic runCase(input string tag, input longint src, input longint tgt);
    longint eS, eSt, eErr;
    bit seen;
    model(src, tgt, eS, eSt, eErr);
    @(negedge clk);
    srcHz = src[31:0]; targetHz = tgt[31:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8", "busy after start", busy, 1);
    waitDone(seen);
    check("R8", "done seen", seen, 1);
    check(tag, "sampleSel", sampleSel, eS);
    check(tag, "stepSel", stepSel, eSt);
    check(tag, "rateErr", rateErr, eErr);
    @(negedge clk);
    check("R8", "done one cycle", done, 0);
    check("R8", "busy cleared", busy, 0);
  endtask

  task automatic holdCase();
    logic [2:0] s0; logic [5:0] t0; logic e0;
    s0 = sampleSel; t0 = stepSel; e0 = rateErr;
    srcHz = 32'd7; targetHz = 32'd1;
    repeat (20) @(negedge clk);
    check("R7", "sample held", sampleSel, s0);
    check("R7", "step held", stepSel, t0);
    check("R7", "err held", rateErr, e0);
  endtask

  task automatic ignoreCase();
    longint eS, eSt, eErr;
    bit seen;
    int extra;
    model(64'd13600000, 64'd20000, eS, eSt, eErr);
    @(negedge clk);
    srcHz = 32'd13600000; targetHz = 32'd20000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    srcHz = 32'd50000000; targetHz = 32'd3400000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone(seen);
    check("R9", "done seen", seen, 1);
    check("R9", "sampleSel of first", sampleSel, eS);
    check("R9", "stepSel of first", stepSel, eSt);
    check("R9", "rateErr of first", rateErr, eErr);
    extra = 0;
    for (int i = 0; i < 800; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    check("R9", "no extra done", extra, 0);
  endtask

  task automatic resetCase();
    repeat (3) @(negedge clk);
    check("R1", "busy in reset", busy, 0);
    check("R1", "done in reset", done, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "busy", busy, 0);
    check("R1", "done", done, 0);
    check("R1", "outputs", {sampleSel, stepSel, rateErr}, 0);
  endtask

  initial begin
    wait (cyc >= 150000);
    errs++;
    $display("FAIL R8 watchdog expired: actual=%0d expected<%0d", cyc, 150000);
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    resetCase();
    runCase("R5", 64'd50000000, 64'd100000);
    holdCase();
    runCase("R3", 64'd50000000, 64'd400000);
    runCase("R3", 64'd50000000, 64'd400001);
    runCase("R2", 64'd50000000, 64'd5000000);
    runCase("R2", 64'd50000000, 64'd3400000);
    runCase("R5", 64'd13600000, 64'd20000);
    runCase("R6", 64'd200000000, 64'd100000);
    runCase("R6", 64'd100000000, 64'd90000);
    runCase("R10", 64'd50000000, 64'd0);
    runCase("R4", 64'd1, 64'd100000);
    runCase("R4", 64'd26000000, 64'd1000000);
    ignoreCase();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule